// File: doc/BRIEF.md
# Serial-Programmed Clock Fanout Controller

This block steers one of two incoming clocks onto ten outputs. Each output either carries the chosen clock or floats at high impedance. Software or a board controller sets it up over a three-wire serial port: a configuration clock, a data line and an enable.

With the enable high, configuration bits are clocked into an 11-stage shift register. One configuration clock edge after the eleventh bit, the shift register is copied into an 11-bit control register. That register then locks until the next reset.

With the enable low, programming is bypassed. All ten outputs are driven, and the data line picks the clock directly. Every configuration clock edge seen with the enable low resets the sequencer. The clock inputs may run asynchronously to the configuration clock, because the path from a clock input to an output is purely combinational.

The sequencer has three named states:
- `ST_SHIFT` accepts bits and counts them.
- `ST_COMMIT` is entered after the eleventh bit. Its edge copies the word into the control register.
- `ST_LOCKED` ignores every further edge.

Its transitions are:
- reset: any state goes to `ST_SHIFT` on an edge with the enable low.
- ST_SHIFT→ST_COMMIT: taken on the eleventh shifting edge.
- ST_COMMIT→ST_LOCKED: taken on the twelfth edge.
- ST_LOCKED→ST_LOCKED: taken on every later edge.

Top module: `clkfan_serial_ctrl`

## Requirements
- R1: While `cfg_en` is 0, all ten outputs are driven (`out_active` all ones), whatever has been programmed. `cfg_sdi`=0 routes `src_clk0` and `cfg_sdi`=1 routes `src_clk1`.
- R2: A rising `cfg_ck` edge with `cfg_en` low resets the block. The sequencer returns to `ST_SHIFT` with a zero bit count. The configuration seen with `cfg_en` high returns to all outputs enabled with `src_clk0`, even if a word was loaded before.
- R3: With `cfg_en` high in `ST_SHIFT`, each rising `cfg_ck` edge moves `cfg_sdi` into the first shift stage, and every other stage takes the previous stage's value.
- R4: The control register is written only on the twelfth rising edge after reset. Until that edge, the configuration with `cfg_en` high stays all outputs enabled with `src_clk0`.
- R5: Number the bits in the order they are presented, starting at 0. Presented bit k (k = 0..9) enables output 9−k. A value of 1 drives the output; a value of 0 sets `out_active[9−k]`=0 and floats `fan_out[9−k]` at 'z'.
- R6: Presented bit 10 selects the clock: 0 routes `src_clk0` and 1 routes `src_clk1`.
- R7: Once loaded, the configuration does not change on any later `cfg_ck` edge while `cfg_en` stays high.
- R8: The sequencer moves from `ST_SHIFT` to `ST_COMMIT` on the eleventh shifting edge, and from `ST_COMMIT` to `ST_LOCKED` on the next edge. A reset partway through the sequence discards the bits already shifted.
- R9: Every driven output follows the selected clock input combinationally, with no `cfg_ck` edge required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_ck | input | 1 | Serial configuration clock |
| cfg_sdi | input | 1 | Serial configuration data; also selects the clock while `cfg_en` is low |
| cfg_en | input | 1 | High: programmable mode; low: direct mode and reset on `cfg_ck` edges |
| src_clk0 | input | 1 | Clock input 0 |
| src_clk1 | input | 1 | Clock input 1 |
| fan_out | output | 10 | Clock outputs, 'z' when disabled |
| out_active | output | 10 | Per-output drive enable, 1 = output driven |

## Verification
The embedded properties check on every configuration clock edge that:
- an enable-low edge clears the sequencer and restores the default configuration;
- each shifting edge moves the data line into the first stage and advances the other stages;
- the bit count advances by one per shifting edge;
- the commit edge copies the shift register intact;
- the locked state holds the control register steady.

Only the bench scenarios can show the rest:
- the external bit ordering, where presented bit k lands on output 9−k;
- the polarity of the select bit;
- that the eleventh edge does not yet load;
- the direct-mode override of a loaded word;
- that an enabled output follows a clock input between configuration edges.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;

    // Sequencer states of the serial configuration port
    typedef enum logic [1:0] {
        ST_SHIFT  = 2'd0,
        ST_COMMIT = 2'd1,
        ST_LOCKED = 2'd2
    } cfg_state_e;

endpackage

// File: rtl/clkfan_cfg_fsm.sv
module clkfan_cfg_fsm
    import clkfan_pkg::*;
#(
    parameter int CFG_W = 11
) (
    input  logic             ck,
    input  logic             en,
    input  logic             sdi,
    output logic [CFG_W-1:0] ctrl_q
);

    localparam int CNT_W = $clog2(CFG_W + 2);
    // Bit 0 is the clock select (0 = source 0); bits above are output enables
    localparam logic [CFG_W-1:0] CTRL_DEFAULT = {{(CFG_W-1){1'b1}}, 1'b0};
    localparam logic [CNT_W-1:0] LAST_SHIFT   = CNT_W'(CFG_W - 1);

    cfg_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CFG_W-1:0] shreg_q;

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SHIFT:  if (cnt_q == LAST_SHIFT) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_LOCKED;
            ST_LOCKED: state_d = ST_LOCKED;
            default:   state_d = ST_SHIFT;
        endcase
    end

    // State register; an edge with the enable low is the reset
    always_ff @(posedge ck) begin
        if (!en) state_q <= ST_SHIFT;
        else     state_q <= state_d;
    end

    // Shift register, bit counter and control register
    always_ff @(posedge ck) begin
        if (!en) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            ctrl_q  <= CTRL_DEFAULT;
        end else begin
            unique case (state_q)
                ST_SHIFT: begin
                    shreg_q <= {shreg_q[CFG_W-2:0], sdi};
                    cnt_q   <= cnt_q + 1'b1;
                end
                ST_COMMIT: begin
                    ctrl_q <= shreg_q;
                    cnt_q  <= cnt_q + 1'b1;
                end
                ST_LOCKED: ;
                default: ;
            endcase
        end
    end

    // R2: an enable-low edge leaves the sequencer cleared and the default configuration
    p_reset_clears_r2: assert property (@(posedge ck)
        !en |=> (state_q == ST_SHIFT && cnt_q == '0 && ctrl_q == CTRL_DEFAULT));

    // R3: shifting edge inserts the data line at stage 0 and advances the rest
    p_shift_moves_r3: assert property (@(posedge ck) disable iff (!en)
        (state_q == ST_SHIFT) |=>
            (shreg_q[0] == $past(sdi) && shreg_q[CFG_W-1:1] == $past(shreg_q[CFG_W-2:0])));

    // R8: the bit count advances by one on each shifting edge
    p_count_steps_r8: assert property (@(posedge ck) disable iff (!en)
        (state_q == ST_SHIFT) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    // R4: the commit edge copies the shift register and locks
    p_commit_copy_r4: assert property (@(posedge ck) disable iff (!en)
        (state_q == ST_COMMIT) |=> (ctrl_q == $past(shreg_q) && state_q == ST_LOCKED));

    // R7: the locked state holds the control register
    p_locked_hold_r7: assert property (@(posedge ck) disable iff (!en)
        (state_q == ST_LOCKED) |=> ($stable(ctrl_q) && state_q == ST_LOCKED));

endmodule

// File: rtl/clkfan_mode_sel.sv
module clkfan_mode_sel #(
    parameter int NUM_OUT = 10,
    parameter int CFG_W   = NUM_OUT + 1
) (
    input  logic               en,
    input  logic               sdi,
    input  logic [CFG_W-1:0]   ctrl,
    output logic [NUM_OUT-1:0] active,
    output logic               sel
);

    // Direct mode (enable low) overrides the control register
    assign sel = en ? ctrl[0] : sdi;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_act
        assign active[i] = en ? ctrl[i+1] : 1'b1;
    end

endmodule

// File: rtl/clkfan_src_mux.sv
module clkfan_src_mux (
    input  logic sel,
    input  logic clk_a,
    input  logic clk_b,
    output logic clk_y
);

    always_comb begin
        unique case (sel)
            1'b0:    clk_y = clk_a;
            default: clk_y = clk_b;
        endcase
    end

endmodule

// File: rtl/clkfan_serial_ctrl.sv
module clkfan_serial_ctrl #(
    parameter int NUM_OUT = 10
) (
    input  logic               cfg_ck,
    input  logic               cfg_sdi,
    input  logic               cfg_en,
    input  logic               src_clk0,
    input  logic               src_clk1,
    output logic [NUM_OUT-1:0] fan_out,
    output logic [NUM_OUT-1:0] out_active
);

    localparam int CFG_W = NUM_OUT + 1;

    logic [CFG_W-1:0] ctrl;
    logic             sel;
    logic             mux_clk;

    clkfan_cfg_fsm #(.CFG_W(CFG_W)) u_fsm (
        .ck     (cfg_ck),
        .en     (cfg_en),
        .sdi    (cfg_sdi),
        .ctrl_q (ctrl)
    );

    clkfan_mode_sel #(.NUM_OUT(NUM_OUT), .CFG_W(CFG_W)) u_mode (
        .en     (cfg_en),
        .sdi    (cfg_sdi),
        .ctrl   (ctrl),
        .active (out_active),
        .sel    (sel)
    );

    clkfan_src_mux u_mux (
        .sel   (sel),
        .clk_a (src_clk0),
        .clk_b (src_clk1),
        .clk_y (mux_clk)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_pad
        assign fan_out[i] = out_active[i] ? mux_clk : 1'bz;
    end

endmodule

// File: tb/clkfan_serial_ctrl_tb.sv
module clkfan_serial_ctrl_tb;

    logic       clk = 1'b0;
    logic       cfg_sdi = 1'b0;
    logic       cfg_en = 1'b0;
    logic       src_clk0 = 1'b0;
    logic       src_clk1 = 1'b0;
    wire  [9:0] fan_out;
    wire  [9:0] out_active;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk; // 50 MHz

    clkfan_serial_ctrl #(.NUM_OUT(10)) u_dut (
        .cfg_ck     (clk),
        .cfg_sdi    (cfg_sdi),
        .cfg_en     (cfg_en),
        .src_clk0   (src_clk0),
        .src_clk1   (src_clk1),
        .fan_out    (fan_out),
        .out_active (out_active)
    );

    // Words indexed by presentation order: w[k] is the k-th bit shifted in
    localparam logic [10:0] VEC [0:5] = '{11'h7FF, 11'h000, 11'h555, 11'h2AA, 11'h401, 11'h3FE};

    // Expected enables: presented bit k drives output 9-k (R5)
    function automatic logic [9:0] exp_act(input logic [10:0] w);
        logic [9:0] a;
        for (int i = 0; i < 10; i++) a[i] = w[9-i];
        return a;
    endfunction

    // Checks enables and, for both source levels, that active outputs follow the selected input
    task automatic check_cfg(input logic [9:0] ea, input logic es, input string tag);
        for (int ph = 0; ph < 2; ph++) begin
            logic lvl;
            src_clk0 = (ph == 0);
            src_clk1 = (ph != 0);
            #1;
            lvl = es ? src_clk1 : src_clk0;
            checks++;
            if (out_active !== ea) begin
                failures++;
                $display("FAIL %s out_active actual=%b expected=%b", tag, out_active, ea);
            end
            checks++;
            if ((fan_out & ea) !== (ea & {10{lvl}})) begin
                failures++;
                $display("FAIL %s/R9 fan_out actual=%b expected=%b", tag, fan_out & ea, ea & {10{lvl}});
            end
        end
    endtask

    task automatic reset_port();
        @(negedge clk);
        cfg_en = 1'b0;
        @(negedge clk);
    endtask

    // Resets, then shifts a full word; returns at the negedge after edge 11
    task automatic shift_word(input logic [10:0] w);
        reset_port();
        cfg_en = 1'b1;
        for (int k = 0; k < 11; k++) begin
            cfg_sdi = w[k];
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // Reset state (R2): after an enable-low edge, enable high shows the default configuration
        reset_port();
        cfg_en = 1'b1;
        check_cfg(10'h3FF, 1'b0, "R2");

        // Vector table walk, then random words
        for (int v = 0; v < 10; v++) begin
            logic [10:0] w;
            w = (v < 6) ? VEC[v] : 11'($urandom);
            shift_word(w);
            check_cfg(10'h3FF, 1'b0, "R4/R8");   // eleven edges: not loaded yet
            cfg_sdi = ~w[0];
            @(negedge clk);                        // twelfth edge loads
            check_cfg(exp_act(w), w[10], "R5/R6/R3");
            for (int e = 0; e < 3; e++) begin      // later edges change nothing
                cfg_sdi = 1'($urandom);
                @(negedge clk);
                check_cfg(exp_act(w), w[10], "R7");
            end
        end

        // Direct mode overrides a loaded word (R1)
        shift_word(11'h000);
        @(negedge clk);
        check_cfg(10'h000, 1'b0, "R5");
        cfg_en = 1'b0;
        cfg_sdi = 1'b1;
        check_cfg(10'h3FF, 1'b1, "R1");
        cfg_sdi = 1'b0;
        check_cfg(10'h3FF, 1'b0, "R1");
        @(negedge clk);                            // enable-low edge resets
        cfg_en = 1'b1;
        check_cfg(10'h3FF, 1'b0, "R2");

        // Partial shift then reset discards bits (R8)
        reset_port();
        cfg_en = 1'b1;
        for (int k = 0; k < 5; k++) begin
            cfg_sdi = 1'b1;
            @(negedge clk);
        end
        shift_word(11'h4F0);
        check_cfg(10'h3FF, 1'b0, "R8");
        @(negedge clk);
        check_cfg(exp_act(11'h4F0), 1'b1, "R8");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule